// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in-first-out buffer for 18-bit words whose write side and read side run on unrelated clocks. Writers push a word on each write-clock edge where the write enable is high. Readers take words out on the read clock. The block reports empty, full, half-full, almost-empty and almost-full. The two "almost" thresholds come from offset registers. After a master reset each offset holds one of two preset values, chosen by a select input. Software can reload the offsets through the data bus (parallel) or one bit at a time through a serial pin.

A mode input is sampled during master reset and selects one of two output timings. In standard mode, words leave only on a read request, and the two status outputs mean "empty" and "full". In fall-through mode, the first stored word moves into an output stage without any request. The same two outputs then mean "output ready" and "input ready". A partial reset empties the buffer but keeps the offsets and the mode. A retransmit pulse rewinds the read side to the first stored word so the data can be read again. An output-enable input gates the data bus, and a separate drive flag reports when the bus is actively driven.

Top module: `dcfifo_flags`

## Requirements
- R1: Words leave in the order they were written, with values unchanged, while the two clocks run at different rates.
- R2: While `mrst` is high, the buffer is emptied, the mode is taken from `fwft_sel`, and both offsets are set to `OFF_A` when `off_sel`=0 or `OFF_B` when `off_sel`=1.
- R3: While `prst` is high, the buffer is emptied, and the offsets and the mode keep their values.
- R4: In standard mode, `empty_or`=1 exactly when the level is 0. A read loads the oldest word onto `rd_data` at that read-clock edge. A read while empty leaves the pointer and `rd_data` unchanged.
- R5: In standard mode, `full_ir`=1 when the level equals DEPTH. A write while full is dropped, and the write pointer does not move.
- R6: In fall-through mode, the oldest word appears on `rd_data` with no read request. `empty_or`=1 means that word is valid, and it holds steady until a read. `full_ir`=1 means a write will be accepted.
- R7: `half_full`=1 when the write-side level is greater than DEPTH/2.
- R8: `almost_empty`=1 when the read-side memory level is at most the almost-empty offset.
- R9: `almost_full`=1 when the write-side level is at least DEPTH minus the almost-full offset.
- R10: With `ld_en`=1, each write-enabled edge writes `wr_data[AW-1:0]` into an offset instead of the buffer. The first such write goes to the almost-empty offset, the second to the almost-full offset, and the order then repeats.
- R11: With `ld_en`=1, `ser_en`=1 and `wr_en`=0, each write-clock edge shifts `ser_in` into a 2·AW-bit chain. The chain is sent least significant bit of the almost-empty offset first and ends with the most significant bit of the almost-full offset.
- R12: A `rt` pulse moves the read address to 0. Reads are accepted from the second read-clock edge after the pulse, and they return the stored words again from the first one.
- R13: When `out_en`=0, `rd_data` reads 0 and `rd_drive`=0. When `out_en`=1, `rd_drive`=1 and the registered word is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write word, or parallel offset value in its low bits |
| ld_en | input | 1 | Redirects writes and serial shifts to the offset registers |
| ser_en | input | 1 | Serial offset shift enable |
| ser_in | input | 1 | Serial offset bit |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read request |
| out_en | input | 1 | Output enable for the data bus |
| rd_data | output | 18 | Registered read word (0 when not driven) |
| rd_drive | output | 1 | High when the data bus is driven |
| mrst | input | 1 | Master reset, active high |
| prst | input | 1 | Partial reset, active high |
| rt | input | 1 | Retransmit pulse (read clock) |
| fwft_sel | input | 1 | Mode select, sampled during master reset (1 = fall-through) |
| off_sel | input | 1 | Default offset select, sampled during master reset |
| empty_or | output | 1 | Empty (standard) or output ready (fall-through) |
| full_ir | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | More than half occupied |
| almost_empty | output | 1 | Level at or below the almost-empty offset |
| almost_full | output | 1 | Level at or above DEPTH minus the almost-full offset |

## Verification
The buffer is filled one word at a time from empty to full and then drained to empty, with every flag compared at every level against thresholds computed in the bench. Because the default, parallel-loaded and serially loaded offsets all differ, each check separates one offset source from another. Fall-through mode is filled one word beyond the memory depth to show that the output stage counts as extra storage. Partial and master resets are each followed by level probes that tell retained offsets and mode apart from defaults. Retransmit is tried after a partial drain so that a replayed word cannot be confused with a continued one.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    localparam int DATA_W = 18;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HOLD,
        RS_REWIND
    } rd_state_t;

    typedef enum logic {
        LD_AE,
        LD_AF
    } ld_state_t;
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] s1, s2;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= gray_in;
            s2 <= s1;
        end
    end

    // Gray to binary: each bit is the parity of itself and all higher bits
    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(s2 >> i);
        end
    end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int OFF_A = 2,
    parameter int OFF_B = 5
) (
    input  logic          wr_clk,
    input  logic          rst,
    input  logic          mrst,
    input  logic          wr_en,
    input  logic          ld_en,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic [AW-1:0] off_data,
    input  logic          fwft_sel,
    input  logic          off_sel,
    input  logic [AW:0]   rptr_gray,
    output logic [AW:0]   wptr_gray,
    output logic [AW-1:0] wr_addr,
    output logic          wr_fire,
    output logic          full,
    output logic          half_full,
    output logic          almost_full,
    output logic [AW-1:0] ae_off,
    output logic          fwft_mode
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr, wnext, rptr_s, level;
    logic [AW-1:0] af_off;
    ld_state_t     ld_st, ld_nxt;
    logic          par_ld;

    dcfifo_sync #(.W(PW)) u_rsync (
        .clk    (wr_clk),
        .rst    (rst),
        .gray_in(rptr_gray),
        .bin_out(rptr_s)
    );

    assign level   = wptr - rptr_s;
    assign full    = (level == PW'(DEPTH));
    assign wr_fire = wr_en && !ld_en && !full;
    assign par_ld  = ld_en && wr_en;
    assign wnext   = wptr + 1'b1;
    assign wr_addr = wptr[AW-1:0];

    always_ff @(posedge wr_clk or posedge rst) begin
        if (rst) begin
            wptr      <= '0;
            wptr_gray <= '0;
        end else if (wr_fire) begin
            wptr      <= wnext;
            wptr_gray <= wnext ^ (wnext >> 1);
        end
    end

    // Offset-load sequencer: state register
    always_ff @(posedge wr_clk or posedge rst) begin
        if (rst) ld_st <= LD_AE;
        else     ld_st <= ld_nxt;
    end

    // Offset-load sequencer: next state
    always_comb begin
        unique case (ld_st)
            LD_AE:   ld_nxt = par_ld ? LD_AF : LD_AE;
            LD_AF:   ld_nxt = par_ld ? LD_AE : LD_AF;
            default: ld_nxt = LD_AE;
        endcase
    end

    // Configuration: only master reset restores defaults
    always_ff @(posedge wr_clk) begin
        if (mrst) begin
            fwft_mode <= fwft_sel;
            ae_off    <= off_sel ? AW'(OFF_B) : AW'(OFF_A);
            af_off    <= off_sel ? AW'(OFF_B) : AW'(OFF_A);
        end else if (par_ld) begin
            if (ld_st == LD_AE) ae_off <= off_data;
            else                af_off <= off_data;
        end else if (ld_en && ser_en) begin
            {af_off, ae_off} <= {ser_in, af_off, ae_off[AW-1:1]};
        end
    end

    always_comb begin
        half_full   = level > PW'(DEPTH / 2);
        almost_full = level >= (PW'(DEPTH) - {1'b0, af_off});
    end
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              rt,
    input  logic              rd_en,
    input  logic              fwft_mode,
    input  logic [AW-1:0]     ae_off,
    input  logic [AW:0]       wptr_gray,
    input  logic [DATA_W-1:0] mem_q,
    output logic [AW-1:0]     rd_addr,
    output logic [AW:0]       rptr_gray,
    output logic [DATA_W-1:0] q,
    output logic              empty_or,
    output logic              almost_empty
);
    localparam int PW = AW + 1;

    logic [PW-1:0] rptr, rnext, wptr_s, level;
    logic          mem_has, pop;
    rd_state_t     st, nxt;

    dcfifo_sync #(.W(PW)) u_wsync (
        .clk    (rd_clk),
        .rst    (rst),
        .gray_in(wptr_gray),
        .bin_out(wptr_s)
    );

    assign level   = wptr_s - rptr;
    assign mem_has = (level != '0);
    assign rnext   = rptr + 1'b1;
    assign rd_addr = rptr[AW-1:0];
    assign pop     = (st != RS_REWIND) && !rt && mem_has &&
                     (fwft_mode ? ((st == RS_IDLE) || rd_en) : rd_en);

    // Read-side state register
    always_ff @(posedge rd_clk or posedge rst) begin
        if (rst) st <= RS_IDLE;
        else     st <= nxt;
    end

    // Read-side next state
    always_comb begin
        unique case (st)
            RS_IDLE:   nxt = rt ? RS_REWIND : ((fwft_mode && mem_has) ? RS_HOLD : RS_IDLE);
            RS_HOLD:   nxt = rt ? RS_REWIND : ((rd_en && !mem_has) ? RS_IDLE : RS_HOLD);
            RS_REWIND: nxt = RS_IDLE;
            default:   nxt = RS_IDLE;
        endcase
    end

    always_ff @(posedge rd_clk or posedge rst) begin
        if (rst) begin
            rptr      <= '0;
            rptr_gray <= '0;
            q         <= '0;
        end else if (rt) begin
            rptr      <= '0;
            rptr_gray <= '0;
        end else if (pop) begin
            rptr      <= rnext;
            rptr_gray <= rnext ^ (rnext >> 1);
            q         <= mem_q;
        end
    end

    // Read-side outputs
    always_comb begin
        empty_or     = fwft_mode ? (st == RS_HOLD) : !mem_has;
        almost_empty = level <= {1'b0, ae_off};
    end
endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags
    import dcfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OFF_A = 2,
    parameter int OFF_B = 5
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ld_en,
    input  logic              ser_en,
    input  logic              ser_in,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive,
    input  logic              mrst,
    input  logic              prst,
    input  logic              rt,
    input  logic              fwft_sel,
    input  logic              off_sel,
    output logic              empty_or,
    output logic              full_ir,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int AW = $clog2(DEPTH);

    logic              rst_any, wr_fire, full, fwft_mode;
    logic [AW-1:0]     wr_addr, rd_addr, ae_off;
    logic [AW:0]       wptr_gray, rptr_gray;
    logic [DATA_W-1:0] mem_q, q;
    logic [DATA_W-1:0] mem [DEPTH];

    assign rst_any = mrst | prst;

    dcfifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .OFF_A(OFF_A), .OFF_B(OFF_B)) u_wr (
        .wr_clk     (wr_clk),
        .rst        (rst_any),
        .mrst       (mrst),
        .wr_en      (wr_en),
        .ld_en      (ld_en),
        .ser_en     (ser_en),
        .ser_in     (ser_in),
        .off_data   (wr_data[AW-1:0]),
        .fwft_sel   (fwft_sel),
        .off_sel    (off_sel),
        .rptr_gray  (rptr_gray),
        .wptr_gray  (wptr_gray),
        .wr_addr    (wr_addr),
        .wr_fire    (wr_fire),
        .full       (full),
        .half_full  (half_full),
        .almost_full(almost_full),
        .ae_off     (ae_off),
        .fwft_mode  (fwft_mode)
    );

    dcfifo_rd_ctl #(.AW(AW)) u_rd (
        .rd_clk      (rd_clk),
        .rst         (rst_any),
        .rt          (rt),
        .rd_en       (rd_en),
        .fwft_mode   (fwft_mode),
        .ae_off      (ae_off),
        .wptr_gray   (wptr_gray),
        .mem_q       (mem_q),
        .rd_addr     (rd_addr),
        .rptr_gray   (rptr_gray),
        .q           (q),
        .empty_or    (empty_or),
        .almost_empty(almost_empty)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[wr_addr] <= wr_data;
    end

    assign mem_q = mem[rd_addr];

    always_comb begin
        full_ir  = fwft_mode ? !full : full;
        rd_drive = out_en;
        rd_data  = out_en ? q : '0;
    end
endmodule

// File: rtl/dcfifo_flags_chk.sv
module dcfifo_flags_chk #(
    parameter int AW = 4
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          mrst,
    input logic          prst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rt,
    input logic          full,
    input logic          almost_full,
    input logic          empty_or,
    input logic          fwft_mode,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] rd_addr,
    input logic [17:0]   q
);
    assert_full_drops_write_R5: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        (full && wr_en) |=> $stable(wr_addr));

    assert_full_within_af_R9: assert property (@(posedge wr_clk) disable iff (mrst || prst)
        full |-> almost_full);

    assert_empty_drops_read_R4: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        (!fwft_mode && empty_or && rd_en && !rt) |=> $stable(rd_addr));

    assert_rewind_to_zero_R12: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        rt |=> (rd_addr == '0));

    assert_stage_holds_R6: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        (fwft_mode && empty_or && !rd_en && !rt) |=> (empty_or && $stable(q)));
endmodule

bind dcfifo_flags dcfifo_flags_chk #(.AW(AW)) u_chk (
    .wr_clk     (wr_clk),
    .rd_clk     (rd_clk),
    .mrst       (mrst),
    .prst       (prst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .rt         (rt),
    .full       (full),
    .almost_full(almost_full),
    .empty_or   (empty_or),
    .fwft_mode  (fwft_mode),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .q          (q)
);

// File: tb/dcfifo_flags_tb_top.sv
`timescale 1ns/100ps
module dcfifo_flags_tb_top;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int OFF_A = 2;
    localparam int OFF_B = 5;

    logic        wr_clk = 0, rd_clk = 0;
    logic        wr_en = 0, ld_en = 0, ser_en = 0, ser_in = 0;
    logic [17:0] wr_data = 0;
    logic        rd_en = 0, out_en = 1, rt = 0;
    logic        mrst = 1, prst = 0, fwft_sel = 0, off_sel = 0;
    logic [17:0] rd_data;
    logic        rd_drive, empty_or, full_ir, half_full, almost_empty, almost_full;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    dcfifo_flags #(.DEPTH(DEPTH), .OFF_A(OFF_A), .OFF_B(OFF_B)) dut_i (
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .ld_en(ld_en),
        .ser_en(ser_en), .ser_in(ser_in), .rd_clk(rd_clk), .rd_en(rd_en),
        .out_en(out_en), .rd_data(rd_data), .rd_drive(rd_drive), .mrst(mrst),
        .prst(prst), .rt(rt), .fwft_sel(fwft_sel), .off_sel(off_sel),
        .empty_or(empty_or), .full_ir(full_ir), .half_full(half_full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    function automatic int pat(int i);
        return (i * 1237 + 91) & 18'h3FFFF;
    endfunction

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
    endtask

    task automatic wr_word(input int d);
        @(negedge wr_clk);
        wr_en = 1; wr_data = 18'(d);
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic put(input int d);
        wr_word(d);
        settle();
    endtask

    task automatic rd_word();
        @(negedge rd_clk);
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
    endtask

    task automatic do_reset(input bit master, input bit fw, input bit os);
        @(negedge wr_clk);
        fwft_sel = fw; off_sel = os;
        if (master) mrst = 1; else prst = 1;
        repeat (4) @(negedge wr_clk);
        mrst = 0; prst = 0;
        settle();
    endtask

    // Standard-mode flags at level n with offsets ae / af
    task automatic flags_std(input int n, input int ae, input int af);
        chk(int'(empty_or),     int'(n == 0),          "R4 empty flag");
        chk(int'(full_ir),      int'(n == DEPTH),      "R5 full flag");
        chk(int'(half_full),    int'(n > DEPTH / 2),   "R7 half-full");
        chk(int'(almost_empty), int'(n <= ae),         "R8 almost-empty");
        chk(int'(almost_full),  int'(n >= DEPTH - af), "R9 almost-full");
    endtask

    initial begin
        #800000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R2: master reset, standard mode, default offsets A
        do_reset(1, 0, 0);
        flags_std(0, OFF_A, OFF_A);
        chk(int'(rd_drive), 1, "R13 drive with out_en high");

        // R1 / R4 / R5 / R7-R9: fill sweep
        for (int n = 1; n <= DEPTH; n++) begin
            put(pat(n - 1));
            flags_std(n, OFF_A, OFF_A);
        end
        put(pat(99));                       // R5: dropped
        flags_std(DEPTH, OFF_A, OFF_A);
        for (int k = 0; k < DEPTH; k++) begin
            rd_word();
            chk(int'(rd_data), pat(k), "R1 order/data");
            settle();
            flags_std(DEPTH - 1 - k, OFF_A, OFF_A);
        end
        rd_word();                          // R4: read while empty
        chk(int'(rd_data), pat(DEPTH - 1), "R4 read on empty ignored");
        flags_std(0, OFF_A, OFF_A);

        // R13: output enable
        @(negedge rd_clk);
        out_en = 0;
        #1;
        chk(int'(rd_drive), 0, "R13 drive off");
        chk(int'(rd_data), 0, "R13 data gated");
        out_en = 1;
        #1;
        chk(int'(rd_data), pat(DEPTH - 1), "R13 data restored");

        // R12: retransmit
        do_reset(1, 0, 0);
        for (int i = 0; i < 5; i++) wr_word(pat(200 + i));
        settle();
        for (int i = 0; i < 3; i++) begin
            rd_word();
            chk(int'(rd_data), pat(200 + i), "R12 first pass");
        end
        @(negedge rd_clk); rt = 1;
        @(negedge rd_clk); rt = 0;
        @(negedge rd_clk);
        for (int i = 0; i < 5; i++) begin
            rd_word();
            chk(int'(rd_data), pat(200 + i), "R12 replay");
        end

        // R10: parallel load, almost-empty=3 then almost-full=10
        do_reset(1, 0, 0);
        @(negedge wr_clk); ld_en = 1;
        wr_word(3);
        wr_word(10);
        @(negedge wr_clk); ld_en = 0;
        settle();
        chk(int'(empty_or), 1, "R10 load stores no data");
        for (int n = 1; n <= 6; n++) begin
            put(pat(n));
            chk(int'(almost_empty), int'(n <= 3), "R10 ae offset");
            chk(int'(almost_full), int'(n >= DEPTH - 10), "R10 af offset");
        end

        // R3: partial reset keeps offsets
        do_reset(0, 1, 1);                  // selects ignored by partial reset
        chk(int'(empty_or), 1, "R3 emptied");
        chk(int'(full_ir), 0, "R3 mode kept standard");
        for (int n = 1; n <= 4; n++) begin
            put(pat(n));
            chk(int'(almost_empty), int'(n <= 3), "R3 ae offset kept");
        end

        // R2: master reset with off_sel=1 gives OFF_B
        do_reset(1, 0, 1);
        for (int n = 1; n <= DEPTH - OFF_B; n++) begin
            put(pat(n));
            chk(int'(almost_empty), int'(n <= OFF_B), "R2 default B ae");
            chk(int'(almost_full), int'(n >= DEPTH - OFF_B), "R2 default B af");
        end

        // R11: serial load, ae=1 af=7, chain 8'h71 LSB first
        do_reset(1, 0, 0);
        @(negedge wr_clk); ld_en = 1;
        begin
            logic [2*AW-1:0] chain;
            chain = {4'd7, 4'd1};
            for (int i = 0; i < 2 * AW; i++) begin
                @(negedge wr_clk);
                ser_en = 1; ser_in = chain[i];
            end
        end
        @(negedge wr_clk); ser_en = 0; ld_en = 0;
        for (int n = 1; n <= 9; n++) begin
            put(pat(n));
            chk(int'(almost_empty), int'(n <= 1), "R11 serial ae");
            chk(int'(almost_full), int'(n >= DEPTH - 7), "R11 serial af");
        end

        // R6: fall-through mode
        do_reset(1, 1, 0);
        chk(int'(empty_or), 0, "R6 not ready after reset");
        chk(int'(full_ir), 1, "R6 input ready after reset");
        for (int n = 1; n <= DEPTH + 1; n++) begin
            put(pat(300 + n));
            chk(int'(empty_or), 1, "R6 output ready");
            chk(int'(full_ir), int'(n <= DEPTH), "R6 input ready");
        end
        put(pat(999));                      // dropped
        for (int k = 1; k <= DEPTH + 1; k++) begin
            chk(int'(rd_data), pat(300 + k), "R6 fall-through data");
            rd_word();
        end
        chk(int'(empty_or), 0, "R6 drained");

        // R3: partial reset keeps fall-through mode
        do_reset(0, 0, 0);
        put(pat(50));
        chk(int'(empty_or), 1, "R3 mode kept fall-through");
        chk(int'(rd_data), pat(50), "R3 word falls through");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule